// File: doc/BRIEF.md
# USB Low-Speed Suspend and Wake Controller

This block watches the sampled line state of a low-speed USB device and raises two event flags. The suspend flag is set when the bus has stayed idle for a set number of counted cycles. The resume flag is set when the lines move again after that. Firmware clears either flag by writing a 1 to it.

The block also sequences the chip's power-down state. Firmware writes 1 to a power-down bit, and the block then drops the main clock-enable. The power-down bit clears itself in two cases: when a slow wake timer counts out a set number of slow-clock ticks, or when D+ or D- changes. Firmware can then poll its inputs and request power-down again. While powered down, idle time advances only on slow ticks.

The block also drives the data lines when firmware asks. Forced SE0 pulls both lines low. Remote-wakeup K signalling drives D+ high and D- low, and a separate disable bit can block it.

Top module: `usb_lp_sleep_ctrl`

## Requirements
- R1: After reset the control readback is 0x08 (forced-SE0 bit set, all other bits 0), the event readback is 0, clk_en is 1, and the line drivers are enabled with drive_dp=0 and drive_dm=0.
- R2: The suspend flag (event bit 0) is set once IDLE_CYCLES counted cycles pass with no line change. Any change of {line_dp,line_dm} restarts the count. The flag is set only once per idle period.
- R3: The resume flag (event bit 1) is set when the line state changes while the idle count has reached IDLE_CYCLES. A change before that point does not set it.
- R4: Writing the event register (wr_sel=1) clears each flag whose data bit is 1 and leaves flags whose data bit is 0 unchanged.
- R5: Writing the control register (wr_sel=0) with bit 0 = 1 sets the power-down bit (control readback bit 0), and clk_en is 0 from the next cycle on. A control write with bit 0 = 0 does not clear power-down.
- R6: While powered down, the WAKE_TICKS-th slow_tick pulse clears power-down and returns clk_en to 1. Fewer pulses leave it set.
- R7: A change of line state while powered down clears power-down and returns clk_en to 1.
- R8: While powered down, the idle count advances only on slow_tick. With no ticks, the suspend flag is not set, however long the bus stays idle.
- R9: Control bit 3 (forced SE0) enables the drivers with both lines low, one cycle after the control register changes. It takes priority over K.
- R10: Control bit 1 (wake), with bit 2 (wake disable) at 0, drives K (drive_dp=1, drive_dm=0). With bit 2 at 1, or with bit 1 cleared, the drivers are released (drive_en=0).

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock |
| rst | input | 1 | Synchronous active-high reset |
| line_dp | input | 1 | Sampled D+ line state |
| line_dm | input | 1 | Sampled D- line state |
| slow_tick | input | 1 | One-cycle pulse from the slow wake clock |
| wr_en | input | 1 | Register write strobe |
| wr_sel | input | 1 | 0 selects control, 1 selects event flags |
| wr_data | input | REG_W | Write data |
| clk_en | output | 1 | Main oscillator enable, low in power-down |
| drive_en | output | 1 | Data line driver enable |
| drive_dp | output | 1 | Value driven on D+ |
| drive_dm | output | 1 | Value driven on D- |
| ctrl_rd | output | REG_W | Control readback: bit0 power-down, bit1 wake, bit2 wake disable, bit3 forced SE0 |
| evt_rd | output | REG_W | Event readback: bit0 suspend, bit1 resume |

## Verification
The hardest situation to reach is the idle count frozen during power-down. Nothing shows it directly at the ports; it only shows as a suspend flag that never appears. To reach it, the bench clears the flags just after a line change, requests power-down, and then holds slow_tick low for several idle windows. A set suspend flag would prove the count leaked. The bench then wakes the block by moving the lines. The wake-timer boundary is reached by pulsing slow_tick one tick at a time and checking the power-down bit before and after the last tick.

// File: rtl/usb_lp_sleep_pkg.sv
package usb_lp_sleep_pkg;
  localparam int CTRL_PWRDN = 0;
  localparam int CTRL_WAKE  = 1;
  localparam int CTRL_WKDIS = 2;
  localparam int CTRL_SE0   = 3;
  localparam int EVT_SUSP   = 0;
  localparam int EVT_RESUME = 1;
  localparam logic SEL_CTRL = 1'b0;
  localparam logic SEL_EVT  = 1'b1;

  typedef struct packed {
    logic dp;
    logic dm;
  } line_t;

  typedef struct packed {
    logic se0;
    logic wake_dis;
    logic wake;
  } bus_ctrl_t;
endpackage

// File: rtl/usb_lp_idle_mon.sv
module usb_lp_idle_mon
  import usb_lp_sleep_pkg::*;
#(
  parameter int IDLE_CYCLES = 18000
) (
  input  logic  clk,
  input  logic  rst,
  input  line_t line_in,
  input  logic  adv,
  output logic  line_change,
  output logic  susp_pulse,
  output logic  resume_pulse
);
  localparam int CW = $clog2(IDLE_CYCLES + 1);
  localparam logic [CW-1:0] LIMIT = CW'(IDLE_CYCLES);

  line_t         line_q;
  logic [CW-1:0] idle_cnt;
  logic          at_limit;

  assign line_change  = (line_in != line_q);
  assign at_limit     = (idle_cnt == LIMIT);
  assign susp_pulse   = !line_change && adv && (idle_cnt == LIMIT - 1'b1);
  assign resume_pulse = line_change && at_limit;

  always_ff @(posedge clk) begin
    line_q <= line_in;
    if (rst) begin
      idle_cnt <= '0;
    end else if (line_change) begin
      idle_cnt <= '0;
    end else if (adv && !at_limit) begin
      idle_cnt <= idle_cnt + 1'b1;
    end
  end

  assert_idle_restart_R2: assert property (@(posedge clk) disable iff (rst)
    line_change |=> (idle_cnt == '0))
    else $error("idle count not restarted by line change");

  assert_idle_frozen_R8: assert property (@(posedge clk) disable iff (rst)
    (!adv && !line_change) |=> $stable(idle_cnt))
    else $error("idle count moved without advance");
endmodule

// File: rtl/usb_lp_pwr_seq.sv
module usb_lp_pwr_seq #(
  parameter int WAKE_TICKS = 500
) (
  input  logic clk,
  input  logic rst,
  input  logic set_req,
  input  logic slow_tick,
  input  logic line_change,
  output logic pwrdn,
  output logic clk_en
);
  localparam int TW = $clog2(WAKE_TICKS + 1);
  localparam logic [TW-1:0] LAST = TW'(WAKE_TICKS - 1);

  logic          pwrdn_q, pwrdn_d, clk_en_q, expire;
  logic [TW-1:0] tick_cnt;

  assign expire = pwrdn_q && slow_tick && (tick_cnt == LAST);

  always_comb begin
    pwrdn_d = pwrdn_q;
    if (set_req)                             pwrdn_d = 1'b1;
    else if (pwrdn_q && (expire || line_change)) pwrdn_d = 1'b0;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      pwrdn_q  <= 1'b0;
      clk_en_q <= 1'b1;
      tick_cnt <= '0;
    end else begin
      pwrdn_q  <= pwrdn_d;
      clk_en_q <= !pwrdn_d;
      if (!pwrdn_q || expire) tick_cnt <= '0;
      else if (slow_tick)     tick_cnt <= tick_cnt + 1'b1;
    end
  end

  assign pwrdn  = pwrdn_q;
  assign clk_en = clk_en_q;

  assert_clk_gated_R5: assert property (@(posedge clk) disable iff (rst)
    set_req |=> !clk_en_q)
    else $error("clock enable still high after power-down request");

  assert_wake_on_activity_R7: assert property (@(posedge clk) disable iff (rst)
    (pwrdn_q && line_change && !set_req) |=> (!pwrdn_q && clk_en_q))
    else $error("bus activity did not end power-down");
endmodule

// File: rtl/usb_lp_line_drv.sv
module usb_lp_line_drv
  import usb_lp_sleep_pkg::*;
(
  input  logic      clk,
  input  logic      rst,
  input  bus_ctrl_t ctl,
  output logic      drive_en,
  output logic      drive_dp,
  output logic      drive_dm
);
  always_ff @(posedge clk) begin
    if (rst) begin
      drive_en <= 1'b1;
      drive_dp <= 1'b0;
      drive_dm <= 1'b0;
    end else if (ctl.se0) begin
      drive_en <= 1'b1;
      drive_dp <= 1'b0;
      drive_dm <= 1'b0;
    end else if (ctl.wake && !ctl.wake_dis) begin
      drive_en <= 1'b1;
      drive_dp <= 1'b1;
      drive_dm <= 1'b0;
    end else begin
      drive_en <= 1'b0;
      drive_dp <= 1'b0;
      drive_dm <= 1'b0;
    end
  end

  assert_se0_drive_R9: assert property (@(posedge clk) disable iff (rst)
    ctl.se0 |=> (drive_en && !drive_dp && !drive_dm))
    else $error("forced SE0 not driven");

  assert_k_blocked_R10: assert property (@(posedge clk) disable iff (rst)
    (ctl.wake_dis && !ctl.se0) |=> !drive_en)
    else $error("K driven while wake disabled");
endmodule

// File: rtl/usb_lp_sleep_ctrl.sv
module usb_lp_sleep_ctrl
  import usb_lp_sleep_pkg::*;
#(
  parameter int IDLE_CYCLES = 18000,
  parameter int WAKE_TICKS  = 500,
  parameter int REG_W       = 8
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             line_dp,
  input  logic             line_dm,
  input  logic             slow_tick,
  input  logic             wr_en,
  input  logic             wr_sel,
  input  logic [REG_W-1:0] wr_data,
  output logic             clk_en,
  output logic             drive_en,
  output logic             drive_dp,
  output logic             drive_dm,
  output logic [REG_W-1:0] ctrl_rd,
  output logic [REG_W-1:0] evt_rd
);
  line_t     line_s;
  bus_ctrl_t bus_ctl_q;
  logic      ctrl_wr, evt_wr, set_req, pwrdn, adv;
  logic      line_change, susp_pulse, resume_pulse;
  logic      susp_q, resume_q;
  logic      unused_wr_bits;

  assign line_s         = {line_dp, line_dm};
  assign ctrl_wr        = wr_en && (wr_sel == SEL_CTRL);
  assign evt_wr         = wr_en && (wr_sel == SEL_EVT);
  assign set_req        = ctrl_wr && wr_data[CTRL_PWRDN];
  assign adv            = clk_en || slow_tick;
  assign unused_wr_bits = ^wr_data[REG_W-1:4];

  usb_lp_idle_mon #(.IDLE_CYCLES(IDLE_CYCLES)) u_idle (
    .clk(clk), .rst(rst), .line_in(line_s), .adv(adv),
    .line_change(line_change), .susp_pulse(susp_pulse), .resume_pulse(resume_pulse)
  );

  usb_lp_pwr_seq #(.WAKE_TICKS(WAKE_TICKS)) u_pwr (
    .clk(clk), .rst(rst), .set_req(set_req), .slow_tick(slow_tick),
    .line_change(line_change), .pwrdn(pwrdn), .clk_en(clk_en)
  );

  usb_lp_line_drv u_drv (
    .clk(clk), .rst(rst), .ctl(bus_ctl_q),
    .drive_en(drive_en), .drive_dp(drive_dp), .drive_dm(drive_dm)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      bus_ctl_q <= '{se0: 1'b1, wake_dis: 1'b0, wake: 1'b0};
      susp_q    <= 1'b0;
      resume_q  <= 1'b0;
    end else begin
      if (ctrl_wr) begin
        bus_ctl_q.se0      <= wr_data[CTRL_SE0];
        bus_ctl_q.wake_dis <= wr_data[CTRL_WKDIS];
        bus_ctl_q.wake     <= wr_data[CTRL_WAKE];
      end
      susp_q   <= susp_pulse   || (susp_q   && !(evt_wr && wr_data[EVT_SUSP]));
      resume_q <= resume_pulse || (resume_q && !(evt_wr && wr_data[EVT_RESUME]));
    end
  end

  always_comb begin
    ctrl_rd             = '0;
    ctrl_rd[CTRL_PWRDN] = pwrdn;
    ctrl_rd[CTRL_WAKE]  = bus_ctl_q.wake;
    ctrl_rd[CTRL_WKDIS] = bus_ctl_q.wake_dis;
    ctrl_rd[CTRL_SE0]   = bus_ctl_q.se0;
    evt_rd              = '0;
    evt_rd[EVT_SUSP]    = susp_q;
    evt_rd[EVT_RESUME]  = resume_q;
  end

  assert_suspend_flag_R2: assert property (@(posedge clk) disable iff (rst)
    susp_pulse |=> susp_q)
    else $error("suspend event not flagged");

  assert_resume_flag_R3: assert property (@(posedge clk) disable iff (rst)
    resume_pulse |=> resume_q)
    else $error("resume event not flagged");

  assert_w1c_clear_R4: assert property (@(posedge clk) disable iff (rst)
    (evt_wr && wr_data[EVT_RESUME] && !resume_pulse) |=> !resume_q)
    else $error("resume flag not cleared by write of 1");
endmodule

// File: tb/usb_lp_sleep_ctrl_bench.sv
module usb_lp_sleep_ctrl_bench;
  localparam int IDLE = 20;
  localparam int WAKE = 5;

  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic       line_dp = 1'b0, line_dm = 1'b1;
  logic       slow_tick = 1'b0;
  logic       wr_en = 1'b0, wr_sel = 1'b0;
  logic [7:0] wr_data = '0;
  logic       clk_en, drive_en, drive_dp, drive_dm;
  logic [7:0] ctrl_rd, evt_rd;
  int         checks = 0, errors = 0;

  always #5 clk = ~clk;

  usb_lp_sleep_ctrl #(.IDLE_CYCLES(IDLE), .WAKE_TICKS(WAKE), .REG_W(8)) u_usb_lp_sleep_ctrl (
    .clk(clk), .rst(rst), .line_dp(line_dp), .line_dm(line_dm), .slow_tick(slow_tick),
    .wr_en(wr_en), .wr_sel(wr_sel), .wr_data(wr_data), .clk_en(clk_en),
    .drive_en(drive_en), .drive_dp(drive_dp), .drive_dm(drive_dm),
    .ctrl_rd(ctrl_rd), .evt_rd(evt_rd)
  );

  task automatic check(input string req, input int got, input int exp);
    checks++;
    if (got != exp) begin
      errors++;
      $display("FAIL %s: got 0x%0h expected 0x%0h", req, got, exp);
    end
  endtask

  task automatic cyc(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic wr(input logic sel, input logic [7:0] d);
    wr_en = 1'b1; wr_sel = sel; wr_data = d;
    cyc(1);
    wr_en = 1'b0; wr_data = '0;
  endtask

  task automatic toggle_line();
    line_dp = ~line_dp; line_dm = ~line_dm;
    cyc(1);
  endtask

  task automatic tick();
    slow_tick = 1'b1;
    cyc(1);
    slow_tick = 1'b0;
  endtask

  task automatic t_reset();
    rst = 1'b1; cyc(3); rst = 1'b0; cyc(1);
    check("R1 ctrl", ctrl_rd, 8'h08);
    check("R1 evt", evt_rd, 0);
    check("R1 clk_en", clk_en, 1);
    check("R1 drive", {drive_en, drive_dp, drive_dm}, 3'b100);
  endtask

  task automatic t_drive();
    wr(1'b0, 8'h0A); cyc(2);
    check("R9 se0 over K", {drive_en, drive_dp, drive_dm}, 3'b100);
    wr(1'b0, 8'h02); cyc(2);
    check("R10 K drive", {drive_en, drive_dp, drive_dm}, 3'b110);
    wr(1'b0, 8'h06); cyc(2);
    check("R10 wake disabled", drive_en, 0);
    wr(1'b0, 8'h02); cyc(2);
    wr(1'b0, 8'h00); cyc(2);
    check("R10 K released", drive_en, 0);
    wr(1'b0, 8'h08); cyc(2);
    check("R9 se0", {drive_en, drive_dp, drive_dm}, 3'b100);
    wr(1'b0, 8'h00); cyc(1);
  endtask

  task automatic t_suspend();
    wr(1'b1, 8'h03);
    toggle_line(); cyc(IDLE - 4);
    check("R2 early", evt_rd[0], 0);
    cyc(8);
    check("R2 suspend set", evt_rd[0], 1);
    wr(1'b1, 8'h03);
    toggle_line(); cyc(IDLE - 5); toggle_line(); cyc(IDLE - 5);
    check("R2 restart", evt_rd[0], 0);
    cyc(8);
    check("R2 after restart", evt_rd[0], 1);
    wr(1'b1, 8'h01); cyc(2 * IDLE);
    check("R2 once per idle", evt_rd[0], 0);
  endtask

  task automatic t_resume();
    wr(1'b1, 8'h03);
    toggle_line();
    check("R3 resume set", evt_rd[1], 1);
    wr(1'b1, 8'h03); cyc(3);
    toggle_line(); cyc(1);
    check("R3 no resume before idle", evt_rd[1], 0);
  endtask

  task automatic t_w1c();
    cyc(IDLE + 4);
    toggle_line();
    check("R4 both flags", evt_rd, 8'h03);
    wr(1'b1, 8'h00);
    check("R4 write 0 keeps", evt_rd, 8'h03);
    wr(1'b1, 8'h02);
    check("R4 clear resume", evt_rd, 8'h01);
    wr(1'b1, 8'h01);
    check("R4 clear suspend", evt_rd, 8'h00);
  endtask

  task automatic t_pwrdn_timer();
    wr(1'b0, 8'h01);
    check("R5 pwrdn set", ctrl_rd[0], 1);
    check("R5 clk gated", clk_en, 0);
    wr(1'b0, 8'h00);
    check("R5 write 0 ignored", ctrl_rd[0], 1);
    for (int i = 0; i < WAKE - 1; i++) tick();
    check("R6 before expiry", clk_en, 0);
    tick();
    check("R6 pwrdn cleared", ctrl_rd[0], 0);
    check("R6 clk restored", clk_en, 1);
  endtask

  task automatic t_frozen_and_activity();
    toggle_line();
    wr(1'b1, 8'h03);
    wr(1'b0, 8'h01);
    cyc(3 * IDLE);
    check("R8 no suspend while frozen", evt_rd[0], 0);
    check("R8 still powered down", clk_en, 0);
    toggle_line();
    check("R7 pwrdn cleared", ctrl_rd[0], 0);
    check("R7 clk restored", clk_en, 1);
  endtask

  initial begin
    #2_000_000;
    checks++; errors++;
    $display("FAIL watchdog: got timeout expected completion");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    cyc(1);
    t_reset();
    t_drive();
    t_suspend();
    t_resume();
    t_w1c();
    t_pwrdn_timer();
    t_frozen_and_activity();
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule